// File: doc/BRIEF.md
# UART Receive Queue and FIFO Control

This block holds received characters for a register-mapped UART and answers host reads of the receive and line-status registers. It works in one of two modes. In single-register mode a single holding slot keeps the latest character. In queued mode a 16-entry first-in first-out store keeps characters, and a programmable trigger level decides when the host is asked to drain it.

The host controls the block through writes to an 8-bit queue control register. These writes turn queued mode on and off, pick the trigger level and issue one-shot flush commands. The block drives one-cycle pulses that the surrounding interrupt logic uses to set or cancel the receive-data and line-status conditions. It also drives a pulse telling the transmit side to flush its queue and flag itself empty.

Top module: `uart_rx_queue`

## Requirements
- R1: After reset the queue is empty, every status bit is 0, the stored control value is 0x00, queued mode is off, the trigger level is 1 and the read data is 0x00.
- R2: Control bits 5:4 are never stored. A control write with bit 0 clear changes only bit 0 of the stored value, which becomes 0. Bits 7:1 are applied only when bit 0 is 1 in the same write.
- R3: With bit 0 set, control bits 7:6 pick the trigger level: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14 characters. Bit 3 is stored as written.
- R4: A control write that switches queued mode on while it is off, or any write with bit 0 clear, flushes both sides. The receive side empties and a one-cycle `tx_flush` pulse is issued.
- R5: When queued mode is already on, bit 1 flushes the receive side and bit 2 pulses `tx_flush`. Neither bit is kept in the stored value.
- R6: A receive flush empties the queue, clears data-ready and all error bits, and pulses `rx_cond_cancel`. A character arriving in the same cycle is dropped.
- R7: In queued mode a character arriving with 16 held and no read in the same cycle is dropped. The overrun bit is set and `ls_cond_set` pulses.
- R8: In queued mode `rx_cond_set` pulses in the cycle after a write that raises the occupancy to exactly the trigger level.
- R9: In single-register mode a new character replaces the held one. If data-ready was set and no read happened in the same cycle, overrun is set and `ls_cond_set` pulses. Otherwise data-ready is set and `rx_cond_set` pulses.
- R10: Line status layout is bit 0 data-ready, bit 1 overrun, bit 2 parity, bit 3 framing, bit 4 break. A character stored with an error flag sets that bit and pulses `ls_cond_set`. A line-status read returns the current value, and the error bits are 0 in the cycle after it.
- R11: Characters come out in arrival order. Data-ready drops once the last one is read, and the read data is 0x00 while the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | A received character is presented this cycle |
| rx_data | input | 8 | Received character |
| rx_perr | input | 1 | Parity error flag of the character |
| rx_ferr | input | 1 | Framing error flag of the character |
| rx_brk | input | 1 | Break flag of the character |
| rbr_rd | input | 1 | Host read of the receive register (pops one character) |
| rbr_data | output | 8 | Character at the head of the queue, 0x00 when empty |
| lsr_rd | input | 1 | Host read of the line status register |
| line_status | output | 5 | Line status bits owned by this block |
| fcr_we | input | 1 | Host write of the queue control register |
| fcr_wdata | input | 8 | Control write value |
| fcr_value | output | 8 | Stored control value |
| trig_level | output | 5 | Current trigger level in characters |
| rx_cond_set | output | 1 | Pulse: raise the receive-data condition |
| ls_cond_set | output | 1 | Pulse: raise the line-status condition |
| rx_cond_cancel | output | 1 | Pulse: cancel pending receive, line-status and timeout conditions |
| tx_flush | output | 1 | Pulse: flush transmit queue and set its empty flags |

## Verification
On every cycle the assertions check that the reserved and one-shot control bits never appear in the stored value. They also check that a cancel pulse always leaves data-ready low and that a receive pulse comes only with data present. A line-status pulse must always show an error bit, and an empty queue must read as zero. Trigger decoding, arrival order, the exact cycle of the trigger pulse, overrun at a full queue and overwrite in single-register mode depend on stimulus sequences, so only the directed scenarios show them.

// File: rtl/uart_rx_queue.sv
module uart_rx_queue #(
  parameter int DEPTH = 16,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_perr,
  input  logic          rx_ferr,
  input  logic          rx_brk,
  input  logic          rbr_rd,
  output logic [DW-1:0] rbr_data,
  input  logic          lsr_rd,
  output logic [4:0]    line_status,
  input  logic          fcr_we,
  input  logic [7:0]    fcr_wdata,
  output logic [7:0]    fcr_value,
  output logic [4:0]    trig_level,
  output logic          rx_cond_set,
  output logic          ls_cond_set,
  output logic          rx_cond_cancel,
  output logic          tx_flush
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] rptr, wptr;
  logic [CW-1:0] cnt;
  logic          oe, pe, fe, bi;
  logic [7:0]    fcr;
  logic [4:0]    trig;

  wire       fifo_on = fcr[0];
  wire [7:0] fv      = fcr_wdata & 8'hCF;
  wire       clr_rx  = fcr_we && (!fv[0] || !fifo_on || fv[1]);
  wire       clr_tx  = fcr_we && (!fv[0] || !fifo_on || fv[2]);
  wire       nonempty = (cnt != '0);
  wire       pop     = rbr_rd && nonempty;
  wire       arrive  = rx_valid && !clr_rx;
  wire       room    = !fifo_on || (cnt < CW'(DEPTH)) || pop;
  wire       push    = arrive && room;
  wire       fovr    = arrive && !room;
  wire       sovr    = arrive && !fifo_on && nonempty && !pop;
  wire       ovr     = fovr || sovr;
  wire       has_err = rx_perr || rx_ferr || rx_brk;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [4:0] decode_trig(input logic [1:0] sel);
    case (sel)
      2'b00:   return 5'd1;
      2'b01:   return 5'd4;
      2'b10:   return 5'd8;
      default: return 5'd14;
    endcase
  endfunction

  assign rbr_data    = nonempty ? mem[rptr] : '0;
  assign line_status = {bi, fe, pe, oe, nonempty};
  assign fcr_value   = fcr;
  assign trig_level  = trig;

  always_ff @(posedge clk) begin
    if (push) mem[fifo_on ? wptr : rptr] <= rx_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rptr <= '0; wptr <= '0; cnt <= '0;
      oe <= 1'b0; pe <= 1'b0; fe <= 1'b0; bi <= 1'b0;
      fcr <= 8'h00; trig <= 5'd1;
      rx_cond_set <= 1'b0; ls_cond_set <= 1'b0;
      rx_cond_cancel <= 1'b0; tx_flush <= 1'b0;
    end else begin
      rx_cond_set    <= 1'b0;
      ls_cond_set    <= 1'b0;
      rx_cond_cancel <= clr_rx;
      tx_flush       <= clr_tx;
      if (fcr_we) begin
        if (fv[0]) begin
          fcr  <= {fv[7:6], 2'b00, fv[3], 3'b001};
          trig <= decode_trig(fv[7:6]);
        end else begin
          fcr[0] <= 1'b0;
        end
      end
      if (clr_rx) begin
        rptr <= '0; wptr <= '0; cnt <= '0;
        oe <= 1'b0; pe <= 1'b0; fe <= 1'b0; bi <= 1'b0;
      end else begin
        if (fifo_on) begin
          if (push) wptr <= nxt(wptr);
          if (pop)  rptr <= nxt(rptr);
          cnt <= cnt + CW'(push) - CW'(pop);
          rx_cond_set <= push && !pop && ({1'b0, cnt} + 1'b1 == (CW+1)'(trig));
        end else begin
          if (push)     cnt <= CW'(1);
          else if (pop) cnt <= '0;
          rx_cond_set <= push && !sovr;
        end
        oe <= (oe && !lsr_rd) || ovr;
        pe <= (pe && !lsr_rd) || (push && rx_perr);
        fe <= (fe && !lsr_rd) || (push && rx_ferr);
        bi <= (bi && !lsr_rd) || (push && rx_brk);
        ls_cond_set <= ovr || (push && has_err);
      end
    end
  end
endmodule

// File: rtl/uart_rx_queue_chk.sv
module uart_rx_queue_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_valid,
  input logic       lsr_rd,
  input logic [7:0] rbr_data,
  input logic [4:0] line_status,
  input logic [7:0] fcr_value,
  input logic       rx_cond_set,
  input logic       ls_cond_set,
  input logic       rx_cond_cancel
);
  // R2
  reserved_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fcr_value[5:4] == 2'b00);
  // R5
  oneshot_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fcr_value[2:1] == 2'b00);
  // R6
  cancel_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cond_cancel |-> (line_status == 5'b0));
  // R8
  rx_pulse_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cond_set |-> line_status[0]);
  // R7
  ls_pulse_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ls_cond_set |-> (line_status[4:1] != 4'b0));
  // R10
  lsr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd && !rx_valid) |=> (line_status[4:2] == 3'b0));
  // R11
  empty_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !line_status[0] |-> (rbr_data == 8'h00));
endmodule

bind uart_rx_queue uart_rx_queue_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .lsr_rd(lsr_rd),
  .rbr_data(rbr_data), .line_status(line_status), .fcr_value(fcr_value),
  .rx_cond_set(rx_cond_set), .ls_cond_set(ls_cond_set),
  .rx_cond_cancel(rx_cond_cancel)
);

// File: tb/tb_uart_rx_queue.sv
module tb_uart_rx_queue;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_valid = 1'b0, rx_perr = 1'b0, rx_ferr = 1'b0, rx_brk = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic       rbr_rd = 1'b0, lsr_rd = 1'b0, fcr_we = 1'b0;
  logic [7:0] fcr_wdata = 8'h00;
  logic [7:0] rbr_data, fcr_value;
  logic [4:0] line_status, trig_level;
  logic       rx_cond_set, ls_cond_set, rx_cond_cancel, tx_flush;
  int tests = 0, fails = 0;

  always #2 clk = ~clk;

  uart_rx_queue dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_brk(rx_brk),
    .rbr_rd(rbr_rd), .rbr_data(rbr_data), .lsr_rd(lsr_rd),
    .line_status(line_status), .fcr_we(fcr_we), .fcr_wdata(fcr_wdata),
    .fcr_value(fcr_value), .trig_level(trig_level),
    .rx_cond_set(rx_cond_set), .ls_cond_set(ls_cond_set),
    .rx_cond_cancel(rx_cond_cancel), .tx_flush(tx_flush)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk); #1;
    rx_valid = 0; rx_perr = 0; rx_ferr = 0; rx_brk = 0;
    rbr_rd = 0; lsr_rd = 0; fcr_we = 0;
  endtask

  task automatic send(input logic [7:0] d, input logic [2:0] fl);
    rx_valid = 1; rx_data = d; {rx_brk, rx_ferr, rx_perr} = fl; step();
  endtask

  task automatic wfcr(input logic [7:0] v);
    fcr_we = 1; fcr_wdata = v; step();
  endtask

  task automatic rd(output logic [7:0] d);
    d = rbr_data; rbr_rd = 1; step();
  endtask

  task automatic t_reset;
    chk("R1", "status", line_status, 0);
    chk("R1", "fcr", fcr_value, 0);
    chk("R1", "trig", trig_level, 1);
    chk("R1", "rdata", rbr_data, 0);
  endtask

  task automatic t_single;
    logic [7:0] d;
    send(8'hA5, 0);
    chk("R9", "dr", line_status, 5'b00001);
    chk("R9", "rx pulse", rx_cond_set, 1);
    send(8'h3C, 0);
    chk("R9", "overrun", line_status, 5'b00011);
    chk("R9", "ls pulse", ls_cond_set, 1);
    chk("R9", "no rx pulse", rx_cond_set, 0);
    rd(d);
    chk("R9", "overwritten data", d, 8'h3C);
    chk("R11", "dr dropped", line_status[0], 0);
    rd(d);
    chk("R11", "empty read", d, 0);
  endtask

  task automatic t_lsr;
    logic [4:0] v;
    v = line_status; lsr_rd = 1; step();
    chk("R10", "lsr returned", v, 5'b00010);
    chk("R10", "errors cleared", line_status, 0);
    send(8'h11, 3'b101);
    chk("R10", "pe+brk set", line_status, 5'b10101);
    chk("R10", "ls pulse", ls_cond_set, 1);
    lsr_rd = 1; step();
    chk("R10", "dr kept, errs cleared", line_status, 5'b00001);
  endtask

  task automatic t_mode;
    wfcr(8'h31);
    chk("R2", "reserved ignored", fcr_value, 8'h01);
    chk("R4", "tx flush on enable", tx_flush, 1);
    chk("R4", "rx cleared on enable", line_status, 0);
    chk("R6", "cancel pulse", rx_cond_cancel, 1);
    send(8'h22, 0);
    wfcr(8'hC8);
    chk("R2", "disable only bit0", fcr_value, 8'h00);
    chk("R2", "trig unchanged", trig_level, 1);
    chk("R4", "flush on disable", tx_flush, 1);
    chk("R4", "rx empty on disable", line_status, 0);
  endtask

  task automatic t_trig;
    wfcr(8'h41); chk("R3", "trig 01", trig_level, 4);
    wfcr(8'h81); chk("R3", "trig 10", trig_level, 8);
    wfcr(8'hC1); chk("R3", "trig 11", trig_level, 14);
    wfcr(8'h09); chk("R3", "trig 00", trig_level, 1);
    chk("R3", "bit3 kept", fcr_value, 8'h09);
    chk("R5", "no flush when on", tx_flush, 0);
  endtask

  task automatic t_fifo;
    logic [7:0] d;
    wfcr(8'h41);
    for (int i = 0; i < 3; i++) begin
      send(8'h50 + 8'(i), 0);
      chk("R8", "below trigger", rx_cond_set, 0);
    end
    send(8'h53, 0);
    chk("R8", "trigger reached", rx_cond_set, 1);
    for (int i = 0; i < 4; i++) begin
      rd(d);
      chk("R11", "order", d, 8'h50 + 8'(i));
    end
    chk("R11", "dr after last", line_status[0], 0);
  endtask

  task automatic t_full;
    logic [7:0] d;
    for (int i = 0; i < 16; i++) send(8'h80 + 8'(i), 0);
    chk("R7", "full no overrun", line_status, 5'b00001);
    send(8'hEE, 0);
    chk("R7", "overrun", line_status, 5'b00011);
    chk("R7", "ls pulse", ls_cond_set, 1);
    for (int i = 0; i < 16; i++) begin
      rd(d);
      chk("R7", "kept data", d, 8'h80 + 8'(i));
    end
    chk("R7", "dropped char absent", line_status[0], 0);
    lsr_rd = 1; step();
  endtask

  task automatic t_clear;
    send(8'h01, 3'b010);
    send(8'h02, 0);
    wfcr(8'h03);
    chk("R6", "rx cleared", line_status, 0);
    chk("R6", "cancel", rx_cond_cancel, 1);
    chk("R5", "no tx flush", tx_flush, 0);
    chk("R5", "bit1 not stored", fcr_value, 8'h01);
    wfcr(8'h05);
    chk("R5", "tx flush", tx_flush, 1);
    chk("R5", "no cancel", rx_cond_cancel, 0);
    chk("R5", "bit2 not stored", fcr_value, 8'h01);
    rx_valid = 1; rx_data = 8'h77; fcr_we = 1; fcr_wdata = 8'h03; step();
    chk("R6", "arrival dropped", line_status, 0);
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    step(); step();
    rst_n = 1; step();
    t_reset();
    t_single();
    t_lsr();
    t_mode();
    t_trig();
    t_fifo();
    t_full();
    t_clear();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule